// File: doc/BRIEF.md
# MAC Power-Down Wakeup Controller

This block holds the power-management state of a MAC receiver. Software writes a control word with three fields: a power-down request, an enable for magic-packet detection and an enable for wakeup-frame detection. While the block is powered down it raises a drop signal, so that every received frame is discarded before it reaches the application. The block leaves power-down only when an enabled wakeup event is detected while it is powered down.

Two sources can produce a wakeup event. The first is a magic-packet detector inside the block. It watches the receive byte stream for a run of at least six 0xFF bytes followed directly by sixteen back-to-back copies of the station address, and it accepts the frame only if the frame ends with good status. The second is a one-cycle match pulse from an external wakeup-frame filter. When an event wakes the block, a sticky status bit records which source caused the wakeup. A level interrupt stays high until software clears the status with a read strobe.

Top module: `mac_pm_wake`

## Requirements
- R1: While `rst` is high and after it is released, `sleeping`, `rx_drop`, `magic_seen`, `wkf_seen` and `irq` are 0, and both detection enables are 0.
- R2: A cycle with `ctrl_we`=1 loads `ctrl_magic_en` and `ctrl_frame_en` into the enables. If `ctrl_sleep`=1 in that cycle, `sleeping` is 1 from the next cycle. Writing `ctrl_sleep`=0 does not end power-down.
- R3: `rx_drop` is 1 in exactly the cycles in which `sleeping` is 1.
- R4: A magic packet is recognised when a run of six or more consecutive 0xFF bytes is followed immediately by 16 consecutive copies of `station_addr`, sent most significant byte first (`station_addr[47:40]` first). The pattern may start anywhere in the frame, and a broken partial pattern may come before it. Only cycles with `rx_valid`=1 carry bytes, so idle cycles between bytes do not break the pattern.
- R5: A magic packet counts only if its frame ends with a byte that has `rx_last`=1 and `rx_good`=1. A frame with bad ending status, fewer than 16 copies, or fewer than six leading 0xFF bytes produces no event.
- R6: A one-cycle `wkf_hit` pulse is a wakeup-frame event.
- R7: An enabled event that occurs while powered down sets the matching status bit (`magic_seen` or `wkf_seen`) and clears `sleeping` at the clock edge that samples the final frame byte or the `wkf_hit` pulse.
- R8: An event whose enable is 0 is ignored: `sleeping` stays 1 and no status bit is set.
- R9: An event that occurs while not powered down sets no status bit.
- R10: A status bit stays set until a cycle with `stat_rd`=1 clears it. If a set and a clear fall in the same cycle, the set wins.
- R11: `irq` is high whenever either status bit is set.
- R12: If a write with `ctrl_sleep`=1 coincides with an enabled wakeup event while powered down, the block ends up awake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_we | input | 1 | Control write strobe |
| ctrl_sleep | input | 1 | Power-down request (set only) |
| ctrl_magic_en | input | 1 | Magic-packet detection enable |
| ctrl_frame_en | input | 1 | Wakeup-frame detection enable |
| stat_rd | input | 1 | Status read strobe, clears both status bits |
| station_addr | input | 48 | Station MAC address |
| rx_valid | input | 1 | Receive byte valid |
| rx_data | input | 8 | Receive byte |
| rx_last | input | 1 | Final byte of the frame |
| rx_good | input | 1 | Frame status good, sampled with `rx_last` |
| wkf_hit | input | 1 | Match pulse from the external wakeup-frame filter |
| sleeping | output | 1 | Power-down mode active |
| rx_drop | output | 1 | Discard received frames |
| magic_seen | output | 1 | Wakeup was caused by a magic packet |
| wkf_seen | output | 1 | Wakeup was caused by a wakeup frame |
| irq | output | 1 | Level interrupt |

## Verification
The hardest case to reach from the ports is a magic pattern that restarts. Examples are a run of 0xFF broken by address bytes and then resumed, a run one byte too short, a pattern one copy short, and bytes separated by idle cycles. The bench builds each of these frames byte by byte from a stimulus table. Collisions in a single cycle are driven in directed tests: a status read against a new status set, and a power-down write against a wakeup pulse.

// File: rtl/pm_wake_pkg.sv
package pm_wake_pkg;

    localparam int ADDR_BYTES = 6;
    localparam logic [7:0] SYNC_BYTE = 8'hFF;

    typedef enum logic {
        MP_HUNT = 1'b0,
        MP_ADDR = 1'b1
    } mp_phase_t;

    typedef struct packed {
        logic magic_en;
        logic frame_en;
    } pm_cfg_t;

    typedef struct packed {
        logic magic;
        logic frame;
    } pm_status_t;

    // Byte i of the station address in wire order (most significant first).
    function automatic logic [7:0] addr_byte(input logic [47:0] addr, input logic [2:0] i);
        return addr[8*(ADDR_BYTES-1-int'(i)) +: 8];
    endfunction

endpackage

// File: rtl/pm_magic_det.sv
module pm_magic_det
    import pm_wake_pkg::*;
#(
    parameter int SYNC_LEN = 6,
    parameter int COPIES   = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [47:0] station_addr,
    input  logic        rx_valid,
    input  logic [7:0]  rx_data,
    input  logic        rx_last,
    input  logic        rx_good,
    output logic        magic_hit
);
    localparam int TOTAL = ADDR_BYTES * COPIES;
    localparam int PW    = $clog2(TOTAL + 1);
    localparam int RW    = $clog2(SYNC_LEN + 1);

    mp_phase_t    phase_q, phase_n;
    logic [RW-1:0] run_q, run_n;
    logic [PW-1:0] pos_q, pos_n;
    logic [2:0]    idx_q, idx_n;
    logic          found_q, found_n;
    logic          done_now;
    logic [7:0]    exp_byte;

    always_comb begin
        phase_n   = phase_q;
        run_n     = run_q;
        pos_n     = pos_q;
        idx_n     = idx_q;
        found_n   = found_q;
        done_now  = 1'b0;
        magic_hit = 1'b0;
        exp_byte  = addr_byte(station_addr, idx_q);
        if (rx_valid) begin
            case (phase_q)
                MP_HUNT: begin
                    if (run_q == RW'(SYNC_LEN) && rx_data == addr_byte(station_addr, 3'd0)) begin
                        phase_n = MP_ADDR;
                        pos_n   = PW'(1);
                        idx_n   = 3'd1;
                    end else if (rx_data == SYNC_BYTE) begin
                        if (run_q != RW'(SYNC_LEN))
                            run_n = run_q + RW'(1);
                    end else begin
                        run_n = '0;
                    end
                end
                default: begin
                    if (rx_data == exp_byte) begin
                        if (pos_q == PW'(TOTAL - 1)) begin
                            done_now = 1'b1;
                            found_n  = 1'b1;
                            phase_n  = MP_HUNT;
                            run_n    = '0;
                            pos_n    = '0;
                            idx_n    = '0;
                        end else begin
                            pos_n = pos_q + PW'(1);
                            idx_n = (idx_q == 3'(ADDR_BYTES - 1)) ? 3'd0 : idx_q + 3'd1;
                        end
                    end else begin
                        phase_n = MP_HUNT;
                        pos_n   = '0;
                        idx_n   = '0;
                        run_n   = (rx_data == SYNC_BYTE) ? RW'(1) : '0;
                    end
                end
            endcase
            if (rx_last) begin
                magic_hit = rx_good && (found_q || done_now);
                phase_n   = MP_HUNT;
                run_n     = '0;
                pos_n     = '0;
                idx_n     = '0;
                found_n   = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= MP_HUNT;
            run_q   <= '0;
            pos_q   <= '0;
            idx_q   <= '0;
            found_q <= 1'b0;
        end else begin
            phase_q <= phase_n;
            run_q   <= run_n;
            pos_q   <= pos_n;
            idx_q   <= idx_n;
            found_q <= found_n;
        end
    end

endmodule

// File: rtl/pm_wake_ctl.sv
module pm_wake_ctl
    import pm_wake_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ctrl_we,
    input  logic       ctrl_sleep,
    input  logic       ctrl_magic_en,
    input  logic       ctrl_frame_en,
    input  logic       stat_rd,
    input  logic       magic_evt,
    input  logic       frame_evt,
    output pm_cfg_t    cfg,
    output logic       sleeping,
    output pm_status_t status
);
    pm_cfg_t    cfg_q;
    logic       sleep_q, sleep_n;
    pm_status_t stat_q, stat_n;
    logic       wake;

    always_comb begin
        wake    = sleep_q && (magic_evt || frame_evt);
        sleep_n = sleep_q;
        if (ctrl_we && ctrl_sleep)
            sleep_n = 1'b1;
        if (wake)
            sleep_n = 1'b0;

        stat_n = stat_q;
        if (stat_rd)
            stat_n = '0;
        if (sleep_q && magic_evt)
            stat_n.magic = 1'b1;
        if (sleep_q && frame_evt)
            stat_n.frame = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= '0;
            sleep_q <= 1'b0;
            stat_q  <= '0;
        end else begin
            if (ctrl_we) begin
                cfg_q.magic_en <= ctrl_magic_en;
                cfg_q.frame_en <= ctrl_frame_en;
            end
            sleep_q <= sleep_n;
            stat_q  <= stat_n;
        end
    end

    assign cfg      = cfg_q;
    assign sleeping = sleep_q;
    assign status   = stat_q;

endmodule

// File: rtl/mac_pm_wake.sv
module mac_pm_wake
    import pm_wake_pkg::*;
#(
    parameter int SYNC_LEN = 6,
    parameter int COPIES   = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        ctrl_we,
    input  logic        ctrl_sleep,
    input  logic        ctrl_magic_en,
    input  logic        ctrl_frame_en,
    input  logic        stat_rd,
    input  logic [47:0] station_addr,
    input  logic        rx_valid,
    input  logic [7:0]  rx_data,
    input  logic        rx_last,
    input  logic        rx_good,
    input  logic        wkf_hit,
    output logic        sleeping,
    output logic        rx_drop,
    output logic        magic_seen,
    output logic        wkf_seen,
    output logic        irq
);
    logic       magic_hit;
    logic       magic_evt;
    logic       frame_evt;
    pm_cfg_t    cfg;
    pm_status_t status;

    pm_magic_det #(
        .SYNC_LEN (SYNC_LEN),
        .COPIES   (COPIES)
    ) u_det (
        .clk          (clk),
        .rst          (rst),
        .station_addr (station_addr),
        .rx_valid     (rx_valid),
        .rx_data      (rx_data),
        .rx_last      (rx_last),
        .rx_good      (rx_good),
        .magic_hit    (magic_hit)
    );

    assign magic_evt = magic_hit && cfg.magic_en;
    assign frame_evt = wkf_hit && cfg.frame_en;

    pm_wake_ctl u_ctl (
        .clk           (clk),
        .rst           (rst),
        .ctrl_we       (ctrl_we),
        .ctrl_sleep    (ctrl_sleep),
        .ctrl_magic_en (ctrl_magic_en),
        .ctrl_frame_en (ctrl_frame_en),
        .stat_rd       (stat_rd),
        .magic_evt     (magic_evt),
        .frame_evt     (frame_evt),
        .cfg           (cfg),
        .sleeping      (sleeping),
        .status        (status)
    );

    assign rx_drop    = sleeping;
    assign magic_seen = status.magic;
    assign wkf_seen   = status.frame;
    assign irq        = status.magic || status.frame;

endmodule

// File: rtl/mac_pm_wake_chk.sv
module mac_pm_wake_chk (
    input logic clk,
    input logic rst,
    input logic sleeping,
    input logic magic_seen,
    input logic wkf_seen,
    input logic irq,
    input logic stat_rd,
    input logic magic_evt,
    input logic frame_evt
);
    // R7
    magic_wake_chk: assert property (@(posedge clk) disable iff (rst)
        (sleeping && magic_evt) |=> (!sleeping && magic_seen));

    // R7
    frame_wake_chk: assert property (@(posedge clk) disable iff (rst)
        (sleeping && frame_evt) |=> (!sleeping && wkf_seen));

    // R8
    stay_asleep_chk: assert property (@(posedge clk) disable iff (rst)
        (sleeping && !magic_evt && !frame_evt) |=> sleeping);

    // R10
    magic_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (magic_seen && !stat_rd) |=> magic_seen);

    // R10
    frame_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (wkf_seen && !stat_rd) |=> wkf_seen);

    // R9
    irq_source_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(sleeping));

endmodule

bind mac_pm_wake mac_pm_wake_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .sleeping   (sleeping),
    .magic_seen (magic_seen),
    .wkf_seen   (wkf_seen),
    .irq        (irq),
    .stat_rd    (stat_rd),
    .magic_evt  (magic_evt),
    .frame_evt  (frame_evt)
);

// File: tb/mac_pm_wake_tb.sv
module mac_pm_wake_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ctrl_we = 1'b0, ctrl_sleep = 1'b0, ctrl_magic_en = 1'b0, ctrl_frame_en = 1'b0;
    logic        stat_rd = 1'b0;
    logic [47:0] station_addr = 48'h02_1A_3C_5E_70_91;
    logic        rx_valid = 1'b0, rx_last = 1'b0, rx_good = 1'b0, wkf_hit = 1'b0;
    logic [7:0]  rx_data = 8'h00;
    logic        sleeping, rx_drop, magic_seen, wkf_seen, irq;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    mac_pm_wake u_dut (
        .clk(clk), .rst(rst), .ctrl_we(ctrl_we), .ctrl_sleep(ctrl_sleep),
        .ctrl_magic_en(ctrl_magic_en), .ctrl_frame_en(ctrl_frame_en),
        .stat_rd(stat_rd), .station_addr(station_addr), .rx_valid(rx_valid),
        .rx_data(rx_data), .rx_last(rx_last), .rx_good(rx_good), .wkf_hit(wkf_hit),
        .sleeping(sleeping), .rx_drop(rx_drop), .magic_seen(magic_seen),
        .wkf_seen(wkf_seen), .irq(irq)
    );

    typedef struct packed {
        logic       men;
        logic       fen;
        logic [2:0] kind;
        logic       exp_sleep;
        logic       exp_m;
        logic       exp_w;
    } vec_t;

    // kind: 0 good magic, 1 bad status, 2 fifteen copies, 3 wkf pulse,
    //       4 broken attempt then magic, 5 five 0xFF only, 6 nine 0xFF, 7 idle gaps
    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b0, 3'd0, 1'b0, 1'b1, 1'b0},
        '{1'b0, 1'b1, 3'd0, 1'b1, 1'b0, 1'b0},
        '{1'b1, 1'b1, 3'd1, 1'b1, 1'b0, 1'b0},
        '{1'b1, 1'b0, 3'd2, 1'b1, 1'b0, 1'b0},
        '{1'b0, 1'b1, 3'd3, 1'b0, 1'b0, 1'b1},
        '{1'b1, 1'b0, 3'd3, 1'b1, 1'b0, 1'b0},
        '{1'b1, 1'b0, 3'd4, 1'b0, 1'b1, 1'b0},
        '{1'b1, 1'b0, 3'd5, 1'b1, 1'b0, 1'b0},
        '{1'b1, 1'b0, 3'd6, 1'b0, 1'b1, 1'b0},
        '{1'b1, 1'b1, 3'd7, 1'b0, 1'b1, 1'b0}
    };

    function automatic string vec_req(input int i);
        case (i)
            0, 6, 8, 9: return "R4";
            1, 5:       return "R8";
            2, 3, 7:    return "R5";
            default:    return "R6";
        endcase
    endfunction

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    task automatic check(input logic act, input logic exp, input string req, input string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        ctrl_we = 1'b0; stat_rd = 1'b0; rx_valid = 1'b0; rx_last = 1'b0; wkf_hit = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic wr_ctrl(input logic slp, input logic men, input logic fen);
        ctrl_we = 1'b1; ctrl_sleep = slp; ctrl_magic_en = men; ctrl_frame_en = fen;
        @(negedge clk);
        ctrl_we = 1'b0;
    endtask

    task automatic pulse_wkf();
        wkf_hit = 1'b1;
        @(negedge clk);
        wkf_hit = 1'b0;
    endtask

    task automatic send_frame(input int pre, input bit partial, input int ffn,
                              input int copies, input bit good, input bit gaps);
        logic [7:0] q [$];
        for (int i = 0; i < pre; i++) q.push_back(8'h55);
        if (partial) begin
            for (int i = 0; i < 6; i++) q.push_back(8'hFF);
            for (int i = 0; i < 3; i++) q.push_back(station_addr[8*(5-i) +: 8]);
            q.push_back(8'h00);
        end
        for (int i = 0; i < ffn; i++) q.push_back(8'hFF);
        for (int c = 0; c < copies; c++)
            for (int i = 0; i < 6; i++) q.push_back(station_addr[8*(5-i) +: 8]);
        q.push_back(8'h33);
        q.push_back(8'h33);
        for (int k = 0; k < q.size(); k++) begin
            rx_valid = 1'b1;
            rx_data  = q[k];
            rx_last  = (k == q.size() - 1);
            rx_good  = good;
            @(negedge clk);
            if (gaps && k % 3 == 0) begin
                rx_valid = 1'b0;
                rx_data  = 8'h02;
                rx_last  = 1'b0;
                @(negedge clk);
            end
        end
        rx_valid = 1'b0;
        rx_last  = 1'b0;
    endtask

    task automatic run_kind(input logic [2:0] kind);
        case (kind)
            3'd0: send_frame(2, 0, 6, 16, 1, 0);
            3'd1: send_frame(2, 0, 6, 16, 0, 0);
            3'd2: send_frame(2, 0, 6, 15, 1, 0);
            3'd3: pulse_wkf();
            3'd4: send_frame(3, 1, 6, 16, 1, 0);
            3'd5: send_frame(2, 0, 5, 16, 1, 0);
            3'd6: send_frame(0, 0, 9, 16, 1, 0);
            default: send_frame(1, 0, 6, 16, 1, 1);
        endcase
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin
        // R1 reset state
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check(sleeping, 1'b0, "R1", "sleeping in reset");
        check(irq, 1'b0, "R1", "irq in reset");
        do_reset();
        check(sleeping, 1'b0, "R1", "sleeping after reset");
        check(rx_drop, 1'b0, "R1", "rx_drop after reset");
        check(magic_seen, 1'b0, "R1", "magic_seen after reset");
        check(wkf_seen, 1'b0, "R1", "wkf_seen after reset");
        // R1: enables reset to 0, so a pulse while asleep must not wake
        wr_ctrl(1'b1, 1'b0, 1'b0);
        ctrl_we = 1'b0;
        rst = 1'b1; @(negedge clk); rst = 1'b0; @(negedge clk);
        ctrl_we = 1'b1; ctrl_sleep = 1'b1; @(negedge clk); ctrl_we = 1'b0;
        pulse_wkf();
        check(sleeping, 1'b1, "R1", "enables cleared by reset");

        // Table-driven
        for (int i = 0; i < NV; i++) begin
            do_reset();
            wr_ctrl(1'b1, VECS[i].men, VECS[i].fen);
            run_kind(VECS[i].kind);
            @(negedge clk);
            check(sleeping, VECS[i].exp_sleep, vec_req(i), $sformatf("vec %0d sleeping", i));
            check(magic_seen, VECS[i].exp_m, vec_req(i), $sformatf("vec %0d magic_seen", i));
            check(wkf_seen, VECS[i].exp_w, vec_req(i), $sformatf("vec %0d wkf_seen", i));
            check(irq, VECS[i].exp_m | VECS[i].exp_w, "R11", $sformatf("vec %0d irq", i));
        end

        // R2 / R3: enter sleep, software clear does not exit
        do_reset();
        wr_ctrl(1'b1, 1'b0, 1'b1);
        check(sleeping, 1'b1, "R2", "sleep entered next cycle");
        check(rx_drop, 1'b1, "R3", "drop while asleep");
        wr_ctrl(1'b0, 1'b0, 1'b1);
        check(sleeping, 1'b1, "R2", "write of 0 keeps sleep");

        // R7: wake at the sampling edge
        pulse_wkf();
        check(sleeping, 1'b0, "R7", "awake right after pulse");
        check(wkf_seen, 1'b1, "R7", "cause bit set");
        check(rx_drop, 1'b0, "R3", "drop released on wake");

        // R10: sticky, then cleared by read
        repeat (5) @(negedge clk);
        check(wkf_seen, 1'b1, "R10", "status held");
        check(irq, 1'b1, "R11", "irq held");
        stat_rd = 1'b1; @(negedge clk); stat_rd = 1'b0;
        check(wkf_seen, 1'b0, "R10", "status cleared by read");
        check(irq, 1'b0, "R11", "irq low after clear");

        // R9: event while awake sets nothing
        pulse_wkf();
        check(wkf_seen, 1'b0, "R9", "no status while awake");
        check(irq, 1'b0, "R9", "no irq while awake");

        // R10: set wins over same-cycle clear
        wr_ctrl(1'b1, 1'b1, 1'b1);
        send_frame(0, 0, 6, 16, 1, 0);
        check(magic_seen, 1'b1, "R10", "magic set before collision");
        wr_ctrl(1'b1, 1'b1, 1'b1);
        wkf_hit = 1'b1; stat_rd = 1'b1;
        @(negedge clk);
        wkf_hit = 1'b0; stat_rd = 1'b0;
        check(magic_seen, 1'b0, "R10", "old status cleared");
        check(wkf_seen, 1'b1, "R10", "new set wins over clear");

        // R12: sleep write coinciding with wake event
        do_reset();
        wr_ctrl(1'b1, 1'b0, 1'b1);
        ctrl_we = 1'b1; ctrl_sleep = 1'b1; ctrl_magic_en = 1'b0; ctrl_frame_en = 1'b1;
        wkf_hit = 1'b1;
        @(negedge clk);
        ctrl_we = 1'b0; wkf_hit = 1'b0;
        check(sleeping, 1'b0, "R12", "wake wins over sleep write");
        check(wkf_seen, 1'b1, "R12", "cause recorded");

        summary();
        $finish;
    end

endmodule